// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into the final page table entry for that page. It walks a two-level table held in memory: first a directory entry, then a table entry. A small direct-mapped translation cache sits in front of the walk. Along the way the walker keeps the accessed and dirty flags current in memory, and it combines the permissions of both levels. It then judges the request against the caller's privilege level and the write-protect control bit.

A client presents one request at a time. Each request carries the address, a write flag, the current privilege level, the paging-enable and write-protect bits, and the directory base. The block raises `busy` until it returns a one-cycle response. The response holds the entry, a fault flag and a 3-bit error code. All memory traffic goes through one read/write port that holds each request until it is acknowledged.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `rsp_fault` and `mem_req` are all low.
- R2: Entry bit 0 is Present, bit 1 Writable, bit 2 User, bit 5 Accessed and bit 6 Dirty. The directory entry is read at `dir_base + A[31:22]*4`. The table entry is read at `{pde[31:12],12'h000} + A[21:12]*4`.
- R3: If the directory entry or the table entry has Present clear, the walk stops at once, the response entry is all zero and nothing is cached.
- R4: A fetched directory entry with Accessed clear is written back to its own address with Accessed set, before the table entry is read.
- R5: For a write request the table entry gets Dirty set. The table entry is written back, with Accessed set and Dirty as updated, only if its Accessed bit was clear when fetched.
- R6: The response Writable and User bits are each the AND of the directory and table bits. All other bits come from the updated table entry.
- R7: A completed walk fills a direct-mapped cache slot chosen by the low 4 bits of `A[31:12]`. A repeated request to a cached page responds with the cached entry and no memory traffic. A different page landing in the same slot replaces it.
- R8: A one-cycle `flush` invalidates every cache slot, so the next request walks again.
- R9: `rsp_fault` is set when the entry has Present clear, or when User is clear and the privilege level is nonzero. `rsp_errcode` is entry bits 2:0.
- R10: A write request also faults when write-protect is set and the combined Writable bit is clear.
- R11: With paging disabled the response is `{A[31:12],12'h007}`, with no fault and no memory traffic.
- R12: `busy` rises the cycle after a request is accepted and stays high through the single `rsp_valid` cycle. Requests arriving while busy are ignored. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| req_cpl | input | 2 | Current privilege level |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Write-protect enable |
| dir_base | input | 32 | Page directory base address |
| flush | input | 1 | Invalidate all cache slots |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_entry | output | 32 | Resulting entry |
| rsp_fault | output | 1 | Page fault |
| rsp_errcode | output | 3 | Fault error code |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The checker assumes the memory port acknowledges each access with a single-cycle `mem_ack`, and only while `mem_req` is high. It also assumes `flush` is pulsed only while the block is idle. The bench's memory responder raises `mem_ack` for exactly one cycle in reply to a pending request, and never two cycles in a row. Requests and flushes are driven on the falling edge, and a flush is issued only once the previous response has been seen.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = ADDR_W - OFS_W;
  localparam int IDX_W  = 10;
  localparam int P_BIT  = 0;
  localparam int W_BIT  = 1;
  localparam int U_BIT  = 2;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_DRD, ST_DWB, ST_TRD, ST_TWB, ST_FILL, ST_DONE
  } walk_st_e;

  function automatic logic [ADDR_W-1:0] dir_slot_addr(input logic [ADDR_W-1:0] base,
                                                      input logic [ADDR_W-1:0] lin);
    return base + {{(ADDR_W-IDX_W-2){1'b0}}, lin[ADDR_W-1 -: IDX_W], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_slot_addr(input logic [ADDR_W-1:0] pde,
                                                      input logic [ADDR_W-1:0] lin);
    return {pde[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
         + {{(ADDR_W-IDX_W-2){1'b0}}, lin[OFS_W +: IDX_W], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] merge_levels(input logic [ADDR_W-1:0] pde,
                                                     input logic [ADDR_W-1:0] pte);
    logic [ADDR_W-1:0] r;
    r        = pte;
    r[W_BIT] = pte[W_BIT] & pde[W_BIT];
    r[U_BIT] = pte[U_BIT] & pde[U_BIT];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] flat_entry(input logic [ADDR_W-1:0] lin);
    return {lin[ADDR_W-1:OFS_W], {(OFS_W-3){1'b0}}, 3'b111};
  endfunction
endpackage

// File: rtl/xw_tcache.sv
module xw_tcache #(
  parameter int SLOT_BITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [xw_pkg::VPN_W-1:0]  look_vpn,
  output logic                      hit,
  output logic [xw_pkg::ADDR_W-1:0] hit_entry,
  input  logic                      fill_en,
  input  logic [xw_pkg::VPN_W-1:0]  fill_vpn,
  input  logic [xw_pkg::ADDR_W-1:0] fill_entry
);
  import xw_pkg::*;
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam int TAG_W = VPN_W - SLOT_BITS;

  logic                 slot_v [SLOTS];
  logic [TAG_W-1:0]     slot_t [SLOTS];
  logic [ADDR_W-1:0]    slot_e [SLOTS];
  logic [SLOT_BITS-1:0] look_idx, fill_idx;

  assign look_idx = look_vpn[SLOT_BITS-1:0];
  assign fill_idx = fill_vpn[SLOT_BITS-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [ADDR_W-1:0] e_q;
    logic              wr_here;
    assign wr_here = fill_en && (fill_idx == SLOT_BITS'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       v_q <= 1'b0;
      else if (flush)   v_q <= 1'b0;
      else if (wr_here) v_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (wr_here) begin
        t_q <= fill_vpn[VPN_W-1:SLOT_BITS];
        e_q <= fill_entry;
      end
    end
    assign slot_v[g] = v_q;
    assign slot_t[g] = t_q;
    assign slot_e[g] = e_q;
  end

  assign hit       = slot_v[look_idx] && (slot_t[look_idx] == look_vpn[VPN_W-1:SLOT_BITS]);
  assign hit_entry = slot_e[look_idx];
endmodule

// File: rtl/xw_fault_chk.sv
module xw_fault_chk (
  input  logic                      pg_on,
  input  logic                      is_write,
  input  logic [1:0]                cpl,
  input  logic                      wp_on,
  input  logic [xw_pkg::ADDR_W-1:0] entry,
  output logic                      fault,
  output logic [2:0]                errcode
);
  import xw_pkg::*;
  logic absent, priv_bad, wp_bad;
  assign absent   = !entry[P_BIT];
  assign priv_bad = !entry[U_BIT] && (cpl != 2'd0);
  assign wp_bad   = is_write && wp_on && !entry[W_BIT];
  assign fault    = pg_on && (absent || priv_bad || wp_bad);
  assign errcode  = entry[2:0];
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [xw_pkg::ADDR_W-1:0] req_addr,
  input  logic                      req_write,
  input  logic [1:0]                req_cpl,
  input  logic                      pg_en,
  input  logic                      wp_en,
  input  logic [xw_pkg::ADDR_W-1:0] dir_base,
  input  logic                      cache_hit,
  input  logic [xw_pkg::ADDR_W-1:0] cache_entry,
  output logic [xw_pkg::VPN_W-1:0]  look_vpn,
  output logic                      fill_en,
  output logic [xw_pkg::ADDR_W-1:0] fill_entry,
  output logic                      hit_ev,
  output logic                      busy,
  output logic                      res_valid,
  output logic [xw_pkg::ADDR_W-1:0] res_entry,
  output logic                      cur_pg,
  output logic                      cur_write,
  output logic [1:0]                cur_cpl,
  output logic                      cur_wp,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [xw_pkg::ADDR_W-1:0] mem_addr,
  output logic [xw_pkg::ADDR_W-1:0] mem_wdata,
  input  logic                      mem_ack,
  input  logic [xw_pkg::ADDR_W-1:0] mem_rdata
);
  import xw_pkg::*;
  walk_st_e          st_q;
  logic [ADDR_W-1:0] lin_q, base_q, pde_q, pte_q, res_q;
  logic              wr_q, pg_q, wp_q;
  logic [1:0]        cpl_q;
  logic [ADDR_W-1:0] pte_upd;

  assign pte_upd = mem_rdata | (ADDR_W'(wr_q) << D_BIT) | (ADDR_W'(1) << A_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      lin_q <= '0; base_q <= '0; pde_q <= '0; pte_q <= '0; res_q <= '0;
      wr_q <= 1'b0; pg_q <= 1'b0; wp_q <= 1'b0; cpl_q <= 2'd0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          lin_q <= req_addr; base_q <= dir_base; wr_q <= req_write;
          cpl_q <= req_cpl;  pg_q <= pg_en;      wp_q <= wp_en;
          st_q  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!pg_q) begin
            res_q <= flat_entry(lin_q); st_q <= ST_DONE;
          end else if (cache_hit) begin
            res_q <= cache_entry; st_q <= ST_DONE;
          end else begin
            st_q <= ST_DRD;
          end
        end
        ST_DRD: if (mem_ack) begin
          pde_q <= mem_rdata | (ADDR_W'(1) << A_BIT);
          if (!mem_rdata[P_BIT]) begin
            res_q <= '0; st_q <= ST_DONE;
          end else if (!mem_rdata[A_BIT]) st_q <= ST_DWB;
          else st_q <= ST_TRD;
        end
        ST_DWB: if (mem_ack) st_q <= ST_TRD;
        ST_TRD: if (mem_ack) begin
          pte_q <= pte_upd;
          if (!mem_rdata[P_BIT]) begin
            res_q <= '0; st_q <= ST_DONE;
          end else if (!mem_rdata[A_BIT]) st_q <= ST_TWB;
          else st_q <= ST_FILL;
        end
        ST_TWB: if (mem_ack) st_q <= ST_FILL;
        ST_FILL: begin
          res_q <= merge_levels(pde_q, pte_q); st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign look_vpn   = lin_q[ADDR_W-1:OFS_W];
  assign fill_en    = (st_q == ST_FILL);
  assign fill_entry = merge_levels(pde_q, pte_q);
  assign hit_ev     = (st_q == ST_LOOK) && pg_q && cache_hit;
  assign busy       = (st_q != ST_IDLE);
  assign res_valid  = (st_q == ST_DONE);
  assign res_entry  = res_q;
  assign cur_pg     = pg_q;
  assign cur_write  = wr_q;
  assign cur_cpl    = cpl_q;
  assign cur_wp     = wp_q;
  assign mem_req    = (st_q == ST_DRD) || (st_q == ST_DWB) || (st_q == ST_TRD) || (st_q == ST_TWB);
  assign mem_we     = (st_q == ST_DWB) || (st_q == ST_TWB);
  assign mem_addr   = ((st_q == ST_DRD) || (st_q == ST_DWB)) ? dir_slot_addr(base_q, lin_q)
                                                             : tbl_slot_addr(pde_q, lin_q);
  assign mem_wdata  = (st_q == ST_DWB) ? pde_q : pte_q;
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter int SLOT_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  input  logic        pg_en,
  input  logic        wp_en,
  input  logic [31:0] dir_base,
  input  logic        flush,
  output logic        busy,
  output logic        rsp_valid,
  output logic [31:0] rsp_entry,
  output logic        rsp_fault,
  output logic [2:0]  rsp_errcode,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  import xw_pkg::*;
  logic [VPN_W-1:0]  look_vpn;
  logic              cache_hit;
  logic [ADDR_W-1:0] cache_entry;
  logic              walk_fill_ev;
  logic [ADDR_W-1:0] walk_fill_entry;
  logic              walk_hit_ev;
  logic              cur_pg, cur_write, cur_wp, raw_fault;
  logic [1:0]        cur_cpl;

  xw_tcache #(.SLOT_BITS(SLOT_BITS)) cache_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_vpn(look_vpn), .hit(cache_hit), .hit_entry(cache_entry),
    .fill_en(walk_fill_ev), .fill_vpn(look_vpn), .fill_entry(walk_fill_entry)
  );

  xw_walk_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_cpl(req_cpl), .pg_en(pg_en), .wp_en(wp_en), .dir_base(dir_base),
    .cache_hit(cache_hit), .cache_entry(cache_entry), .look_vpn(look_vpn),
    .fill_en(walk_fill_ev), .fill_entry(walk_fill_entry), .hit_ev(walk_hit_ev),
    .busy(busy), .res_valid(rsp_valid), .res_entry(rsp_entry),
    .cur_pg(cur_pg), .cur_write(cur_write), .cur_cpl(cur_cpl), .cur_wp(cur_wp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  xw_fault_chk fault_i (
    .pg_on(cur_pg), .is_write(cur_write), .cpl(cur_cpl), .wp_on(cur_wp),
    .entry(rsp_entry), .fault(raw_fault), .errcode(rsp_errcode)
  );

  assign rsp_fault = rsp_valid && raw_fault;
endmodule

// File: rtl/xw_checker.sv
module xw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rsp_valid,
  input logic [31:0] rsp_entry,
  input logic        rsp_fault,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        hit_ev,
  input logic        fill_ev,
  input logic [31:0] fill_entry
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R12
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy ##1 (!rsp_valid && !busy)); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]); // R4
  AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> rsp_valid && !mem_req); // R7
  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |-> fill_entry[0] && fill_entry[5]); // R5
  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_entry[0] |-> rsp_fault); // R9
  AST_FAULT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid); // R9
endmodule

bind xlate_walker xw_checker chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_entry(rsp_entry), .rsp_fault(rsp_fault), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .hit_ev(walk_hit_ev), .fill_ev(walk_fill_ev),
  .fill_entry(walk_fill_entry)
);

// File: tb/xlate_walker_tb_top.sv
module xlate_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pg_en = 1'b0, wp_en = 1'b0, flush = 1'b0;
  logic [31:0] req_addr = '0, dir_base = '0;
  logic [1:0] req_cpl = '0;
  logic busy, rsp_valid, rsp_fault, mem_req, mem_we;
  logic [31:0] rsp_entry, mem_addr, mem_wdata;
  logic [2:0] rsp_errcode;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  int n_rd, n_wr;
  logic [31:0] wa_log [0:3];
  logic [31:0] wd_log [0:3];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_cpl(req_cpl), .pg_en(pg_en), .wp_en(wp_en),
    .dir_base(dir_base), .flush(flush), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_entry(rsp_entry), .rsp_fault(rsp_fault), .rsp_errcode(rsp_errcode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[(mem_addr >> 2) & 32'hFFF] = mem_wdata;
        if (n_wr < 4) begin wa_log[n_wr] = mem_addr; wd_log[n_wr] = mem_wdata; end
        n_wr = n_wr + 1;
      end else begin
        mem_rdata <= mem[(mem_addr >> 2) & 32'hFFF];
        n_rd = n_rd + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] lin, input logic wr, input logic [1:0] cpl,
                        input logic pg, input logic wp,
                        output logic [31:0] ent, output logic flt, output logic [2:0] err);
    bit seen = 0;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = lin; req_write = wr; req_cpl = cpl; pg_en = pg; wp_en = wp;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", 32'(busy), 32'd1);
    for (int k = 0; k < 60; k++) begin
      if (rsp_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R12 response arrives", 32'(seen), 32'd1);
    ent = rsp_entry; flt = rsp_fault; err = rsp_errcode;
  endtask

  // Independent prediction of one walk from the current memory image.
  task automatic predict(input logic [31:0] lin, input logic wr, input logic [1:0] cpl,
                         input logic wp, output logic [31:0] ent, output logic flt,
                         output int rd, output int wn,
                         output logic [31:0] ea0, output logic [31:0] ed0,
                         output logic [31:0] ea1, output logic [31:0] ed1);
    logic [31:0] pa, pde, ta, pte, npte;
    rd = 1; wn = 0; ea0 = 0; ed0 = 0; ea1 = 0; ed1 = 0; ent = 0;
    pa  = dir_base + (lin >> 22) * 4;
    pde = mem[(pa >> 2) & 32'hFFF];
    if (pde[0]) begin
      if (!pde[5]) begin ea0 = pa; ed0 = pde | 32'h20; wn = 1; end
      ta  = (pde & 32'hFFFF_F000) + ((lin >> 12) & 32'h3FF) * 4;
      pte = mem[(ta >> 2) & 32'hFFF];
      rd  = 2;
      if (pte[0]) begin
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (!pte[5]) begin
          if (wn == 0) begin ea0 = ta; ed0 = npte; end
          else begin ea1 = ta; ed1 = npte; end
          wn++;
        end
        ent = npte;
        ent[1] = pte[1] & pde[1];
        ent[2] = pte[2] & pde[2];
      end
    end
    flt = !ent[0] || (!ent[2] && cpl != 0) || (wr && wp && !ent[1]);
  endtask

  task automatic walk_and_check(input string tag, input logic [31:0] lin, input logic wr,
                                input logic [1:0] cpl, input logic wp, input bit want_hit,
                                input logic [31:0] hit_ent, output logic [31:0] got);
    logic [31:0] pe, ea0, ed0, ea1, ed1;
    logic pf, gf;
    logic [2:0] ge;
    int rd, wn;
    if (want_hit) begin
      pe = hit_ent; rd = 0; wn = 0; ea0 = 0; ed0 = 0; ea1 = 0; ed1 = 0;
      pf = !pe[0] || (!pe[2] && cpl != 0) || (wr && wp && !pe[1]);
    end else predict(lin, wr, cpl, wp, pe, pf, rd, wn, ea0, ed0, ea1, ed1);
    do_req(lin, wr, cpl, 1'b1, wp, got, gf, ge);
    chk({tag, " R2 R3 R6 entry"}, got, pe);
    chk({tag, " R9 R10 fault"}, 32'(gf), 32'(pf));
    chk({tag, " R9 errcode"}, 32'(ge), 32'(pe[2:0]));
    chk({tag, " R2 R7 reads"}, 32'(n_rd), 32'(rd));
    chk({tag, " R4 R5 writes"}, 32'(n_wr), 32'(wn));
    if (wn > 0 && n_wr > 0) begin
      chk({tag, " R4 R5 wb0 addr"}, wa_log[0], ea0);
      chk({tag, " R4 R5 wb0 data"}, wd_log[0], ed0);
    end
    if (wn > 1 && n_wr > 1) begin
      chk({tag, " R5 wb1 addr"}, wa_log[1], ea1);
      chk({tag, " R5 wb1 data"}, wd_log[1], ed1);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] e1, e2, ent;
    logic flt;
    logic [2:0] err;
    bit stray;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    dir_base = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 rsp_fault", 32'(rsp_fault), 0);
    chk("R1 mem_req", 32'(mem_req), 0);

    // R11: paging disabled
    do_req(32'h1234_5678, 1'b1, 2'd3, 1'b0, 1'b1, ent, flt, err);
    chk("R11 flat entry", ent, 32'h1234_5007);
    chk("R11 no fault", 32'(flt), 0);
    chk("R11 no traffic", 32'(n_rd + n_wr), 0);

    // Sweep over flag combinations at both levels and request attributes
    for (int c = 0; c < 4096; c++) begin
      int d, t;
      logic [31:0] pde, pte, lin;
      logic wr, wp;
      logic [1:0] cpl;
      d = c % 3; t = (c / 3) % 8;
      pde = ((d + 1) << 12) | 32'h100 | (c & 7) | (((c >> 3) & 1) << 5);
      pte = ((32'hA0000 + c) << 12) | 32'h18 | ((c >> 4) & 7) | (((c >> 7) & 1) << 5)
            | (((c >> 8) & 1) << 6);
      mem[d] = pde;
      mem[((d + 1) << 10) + t] = pte;
      wr  = c[9]; cpl = c[10] ? 2'd3 : 2'd0; wp = c[11];
      lin = (d << 22) | (t << 12) | (c & 32'hFFF);
      do_flush();
      walk_and_check("sweep walk", lin, wr, cpl, wp, 1'b0, 32'h0, e1);
      walk_and_check("sweep R7 repeat", lin, wr, cpl, wp, e1 != 0, e1, e2);
    end

    // R7: slot conflict between pages 1 and 17 of directory slot 0
    mem[0] = 32'h0000_1027;
    mem[(32'h1000 >> 2) + 1]  = 32'h1111_1027;
    mem[(32'h1000 >> 2) + 17] = 32'h2222_2027;
    do_flush();
    walk_and_check("R7 fill A", 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, 0, e1);
    walk_and_check("R7 hit A", 32'h0000_1004, 1'b0, 2'd0, 1'b0, 1'b1, e1, e2);
    walk_and_check("R7 conflict B", 32'h0001_1000, 1'b0, 2'd0, 1'b0, 1'b0, 0, e2);
    walk_and_check("R7 A evicted", 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, 0, e1);

    // R8: flush forces a new walk
    walk_and_check("R8 hit before flush", 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b1, e1, e2);
    do_flush();
    walk_and_check("R8 walk after flush", 32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, 0, e2);

    // R12: a request while busy is ignored
    do_flush();
    n_rd = 0; n_wr = 0;
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h0001_1000; req_write = 1'b0;
    req_cpl = 2'd0; pg_en = 1'b1; wp_en = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h0000_1000;
    @(negedge clk); req_valid = 1'b0;
    for (int k = 0; k < 60 && !rsp_valid; k++) @(negedge clk);
    chk("R12 original request served", rsp_entry, 32'h2222_2027);
    stray = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rsp_valid || busy) stray = 1;
    end
    chk("R12 stray request ignored", 32'(stray), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule